// File: doc/BRIEF.md
# Qualified Address Comparator

This block compares one processor access against a programmed address and raises a one-cycle match pulse when the access also meets every programmed qualifier. The qualifiers are the kind of access (fetch, execute with or without a condition result, load, store), the access size, an optional masked comparison of the transferred data, a check of the current context identifier against one of several stored values, and the security state of the access.

Exact-match rules refine the result for instructions that were cancelled and for data accesses that missed the cache or aborted. If a data access must be compared on its data and that data is not yet available, the comparator holds a pending indication. A later data-valid strobe then resolves the pending access to a match or a no-match.

Top module: `qual_addr_cmp`

## Requirements
- R1: The address matches when the access address equals the programmed address with the low bits below the configured size ignored (byte code 00: none, halfword code 01: bit 0, word code 11: bits 1..0). The access size must equal the configured size. Size code 10 never matches.
- R2: The access-type code selects the accesses that may match. Here acc_class is 00 fetch, 01 execute, 10 load and 11 store, and acc_cond_pass gives the condition result of an execute. Type 000 matches a fetch and 001 any execute. Type 010 matches an execute that passed its condition and 011 one that failed it. Type 100 matches a load or a store, 101 a load only, 110 a store only, and 111 nothing.
- R3: For data accesses, data mode 00 skips the data check, 01 requires the masked data to equal the programmed value, and 11 requires it to differ. Mode 10 blocks every match, instruction accesses included.
- R4: A data-mask bit set to 1 removes that data bit from the comparison.
- R5: Context select 00 ignores the context. Codes 1, 2 and 3 require the access context to equal stored value 1, 2 or 3, held in cfg_ctx_vals at bits [31:0], [63:32] and [95:64]. A context-mask bit set to 1 removes that bit from the comparison.
- R6: Security mode 00 ignores the state. Mode 01 matches only when acc_nonsecure is 1, mode 10 only when it is 0, and mode 11 never matches.
- R7: An instruction access with acc_cancel set does not match when exact match is on. It matches when exact match is off.
- R8: A data access with acc_abort set does not match when exact match is on. When exact match is off, an aborted access or one that missed the cache matches without a data check.
- R9: A data access that missed the cache, with exact match on and data mode 01 or 11, raises pending_o in the next cycle with no match. pending_o holds until dv_valid. In the cycle after the strobe, match_o reflects the data check on dv_data and pending_o falls.
- R10: match_o is a single-cycle pulse in the cycle after the qualifying access or strobe. It stays 0 in cycles with neither.
- R11: Synchronous reset clears match_o and pending_o.
- R12: A dv_valid strobe while nothing is pending produces neither a match nor a pending indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 32 | Programmed address |
| cfg_size | input | 2 | Configured size code |
| cfg_type | input | 3 | Access-type code |
| cfg_dmode | input | 2 | Data comparison mode |
| cfg_dval | input | 32 | Programmed data value |
| cfg_dmask | input | 32 | Data mask, 1 = ignore bit |
| cfg_ctx_sel | input | 2 | Context value select |
| cfg_ctx_vals | input | 96 | Three stored context values |
| cfg_ctx_mask | input | 32 | Context mask, 1 = ignore bit |
| cfg_sec | input | 2 | Security mode |
| cfg_exact | input | 1 | Exact-match enable |
| acc_valid | input | 1 | Access present this cycle |
| acc_class | input | 2 | Access class |
| acc_cond_pass | input | 1 | Execute passed its condition |
| acc_cancel | input | 1 | Instruction cancelled |
| acc_miss | input | 1 | Data access missed the cache |
| acc_abort | input | 1 | Data access aborted |
| acc_addr | input | 32 | Access address |
| acc_size | input | 2 | Access size code |
| acc_data | input | 32 | Data of a cache-hit access |
| acc_ctx | input | 32 | Current context identifier |
| acc_nonsecure | input | 1 | Access is in Non-secure state |
| dv_valid | input | 1 | Late data strobe |
| dv_data | input | 32 | Late data value |
| match_o | output | 1 | Match pulse |
| pending_o | output | 1 | A data access waits for its data |

## Verification
A vector table pairs each access-type code with each access class and condition result. This shows whether the type decoder confuses neighbouring codes. The same table moves the access address just inside and just outside the size granule, which shows whether alignment follows the configured size. Directed accesses then vary one qualifier at a time (data equal or unequal, data differing only in masked bits, context against the selected and unselected values, both security states) to show that each qualifier can block a match alone. The cancel, abort and miss flags are tried with exact match on and off. A late strobe is given both with a value that should match and with one that should not, and once with nothing pending, to check that the wait path resolves correctly.

// File: rtl/qac_pkg.sv
package qac_pkg;

    typedef enum logic [1:0] {
        CLS_FETCH = 2'b00,
        CLS_EXEC  = 2'b01,
        CLS_LOAD  = 2'b10,
        CLS_STORE = 2'b11
    } acc_class_e;

    typedef enum logic [2:0] {
        TY_FETCH     = 3'b000,
        TY_EXEC      = 3'b001,
        TY_EXEC_PASS = 3'b010,
        TY_EXEC_FAIL = 3'b011,
        TY_LDST      = 3'b100,
        TY_LOAD      = 3'b101,
        TY_STORE     = 3'b110,
        TY_RSVD      = 3'b111
    } acc_type_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_RSVD = 2'b10,
        SZ_WORD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        DM_OFF  = 2'b00,
        DM_EQ   = 2'b01,
        DM_RSVD = 2'b10,
        DM_NE   = 2'b11
    } dmode_e;

    typedef enum logic [1:0] {
        SEC_ANY  = 2'b00,
        SEC_NS   = 2'b01,
        SEC_S    = 2'b10,
        SEC_RSVD = 2'b11
    } sec_e;

    // Flags of one access that decide the exact-match outcome.
    typedef struct packed {
        logic cancel;
        logic miss;
        logic abort;
    } acc_flags_t;

    function automatic logic is_data(acc_class_e c);
        return (c == CLS_LOAD) || (c == CLS_STORE);
    endfunction

    function automatic logic type_ok(acc_type_e t, acc_class_e c, logic pass);
        logic ok;
        case (t)
            TY_FETCH:     ok = (c == CLS_FETCH);
            TY_EXEC:      ok = (c == CLS_EXEC);
            TY_EXEC_PASS: ok = (c == CLS_EXEC) && pass;
            TY_EXEC_FAIL: ok = (c == CLS_EXEC) && !pass;
            TY_LDST:      ok = is_data(c);
            TY_LOAD:      ok = (c == CLS_LOAD);
            TY_STORE:     ok = (c == CLS_STORE);
            default:      ok = 1'b0;
        endcase
        return ok;
    endfunction

    // Number of address bits ignored below the size granule.
    function automatic int unsigned size_lsb(size_e s);
        int unsigned n;
        case (s)
            SZ_HALF: n = 1;
            SZ_WORD: n = 2;
            default: n = 0;
        endcase
        return n;
    endfunction

    function automatic logic sec_ok(sec_e m, logic nonsecure);
        logic ok;
        case (m)
            SEC_ANY: ok = 1'b1;
            SEC_NS:  ok = nonsecure;
            SEC_S:   ok = !nonsecure;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/qac_addr_ctx.sv
module qac_addr_ctx
    import qac_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CTX_W  = 32,
    parameter int unsigned N_CTX  = 3,
    parameter int unsigned SEL_W  = 2
) (
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  size_e                  cfg_size,
    input  logic [SEL_W-1:0]       cfg_ctx_sel,
    input  logic [N_CTX*CTX_W-1:0] cfg_ctx_vals,
    input  logic [CTX_W-1:0]       cfg_ctx_mask,
    input  sec_e                   cfg_sec,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  size_e                  acc_size,
    input  logic [CTX_W-1:0]       acc_ctx,
    input  logic                   acc_nonsecure,
    output logic                   addr_ok,
    output logic                   ctx_ok,
    output logic                   secure_ok
);

    logic [ADDR_W-1:0] align_mask;
    logic [N_CTX-1:0]  ctx_hit;

    always_comb begin
        align_mask = ~((ADDR_W'(1) << size_lsb(cfg_size)) - ADDR_W'(1));
        addr_ok    = (((acc_addr ^ cfg_addr) & align_mask) == '0)
                     && (acc_size == cfg_size) && (cfg_size != SZ_RSVD);
    end

    // One masked comparator per stored context value.
    for (genvar k = 0; k < N_CTX; k++) begin : g_ctx
        assign ctx_hit[k] =
            (((acc_ctx ^ cfg_ctx_vals[k*CTX_W +: CTX_W]) & ~cfg_ctx_mask) == '0);
    end

    always_comb begin
        ctx_ok = (cfg_ctx_sel == '0);
        for (int k = 0; k < N_CTX; k++) begin
            if (cfg_ctx_sel == SEL_W'(k + 1)) ctx_ok = ctx_hit[k];
        end
    end

    assign secure_ok = sec_ok(cfg_sec, acc_nonsecure);

endmodule

// File: rtl/qac_data_cmp.sv
module qac_data_cmp
    import qac_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  dmode_e            mode,
    input  logic [DATA_W-1:0] cfg_val,
    input  logic [DATA_W-1:0] cfg_mask,
    input  logic [DATA_W-1:0] data,
    output logic              pass
);

    logic equal;

    always_comb begin
        equal = (((data ^ cfg_val) & ~cfg_mask) == '0);
        case (mode)
            DM_OFF:  pass = 1'b1;
            DM_EQ:   pass = equal;
            DM_NE:   pass = !equal;
            default: pass = 1'b0;
        endcase
    end

endmodule

// File: rtl/qac_resolve.sv
module qac_resolve
    import qac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       acc_valid,
    input  logic       base_ok,
    input  logic       data_acc,
    input  acc_flags_t flags,
    input  logic       exact,
    input  dmode_e     dmode,
    input  logic       now_pass,
    input  logic       dv_valid,
    input  logic       late_pass,
    output logic       match_q,
    output logic       pending_q
);

    logic imm_match;
    logic need_wait;
    logic late_match;
    logic accept_wait;

    always_comb begin
        imm_match = 1'b0;
        need_wait = 1'b0;
        if (acc_valid && base_ok) begin
            if (data_acc) begin
                if (flags.abort) begin
                    imm_match = !exact;
                end else if (flags.miss) begin
                    if (exact && (dmode != DM_OFF)) need_wait = 1'b1;
                    else                            imm_match = 1'b1;
                end else begin
                    imm_match = now_pass;
                end
            end else begin
                imm_match = !(flags.cancel && exact);
            end
        end
        late_match  = pending_q && dv_valid && late_pass;
        accept_wait = need_wait && (!pending_q || dv_valid);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q   <= 1'b0;
            pending_q <= 1'b0;
        end else begin
            match_q   <= imm_match || late_match;
            pending_q <= accept_wait || (pending_q && !dv_valid);
        end
    end

    // R11: reset leaves no match and nothing pending
    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (!match_q && !pending_q));

    // R10: no access and no strobe gives no match
    a_r10_idle_no_match: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid && !dv_valid) |=> !match_q);

    // R9: pending holds until the strobe
    a_r9_pending_holds: assert property (@(posedge clk) disable iff (rst)
        (pending_q && !dv_valid) |=> pending_q);

    // R9: strobe with no new access clears pending
    a_r9_strobe_clears: assert property (@(posedge clk) disable iff (rst)
        (pending_q && dv_valid && !acc_valid) |=> !pending_q);

    // R12: strobe with nothing pending has no effect
    a_r12_stray_strobe: assert property (@(posedge clk) disable iff (rst)
        (!pending_q && dv_valid && !acc_valid) |=> (!match_q && !pending_q));

    // R7: exact match rejects a cancelled instruction
    a_r7_cancel_blocks: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !data_acc && flags.cancel && exact && !dv_valid)
        |=> !match_q);

    // R8: exact match rejects an aborted data access
    a_r8_abort_blocks: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && data_acc && flags.abort && exact && !dv_valid)
        |=> !match_q);

endmodule

// File: rtl/qual_addr_cmp.sv
module qual_addr_cmp
    import qac_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CTX_W  = 32,
    parameter int unsigned N_CTX  = 3,
    localparam int unsigned SEL_W = $clog2(N_CTX + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [1:0]             cfg_size,
    input  logic [2:0]             cfg_type,
    input  logic [1:0]             cfg_dmode,
    input  logic [DATA_W-1:0]      cfg_dval,
    input  logic [DATA_W-1:0]      cfg_dmask,
    input  logic [SEL_W-1:0]       cfg_ctx_sel,
    input  logic [N_CTX*CTX_W-1:0] cfg_ctx_vals,
    input  logic [CTX_W-1:0]       cfg_ctx_mask,
    input  logic [1:0]             cfg_sec,
    input  logic                   cfg_exact,
    input  logic                   acc_valid,
    input  logic [1:0]             acc_class,
    input  logic                   acc_cond_pass,
    input  logic                   acc_cancel,
    input  logic                   acc_miss,
    input  logic                   acc_abort,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [1:0]             acc_size,
    input  logic [DATA_W-1:0]      acc_data,
    input  logic [CTX_W-1:0]       acc_ctx,
    input  logic                   acc_nonsecure,
    input  logic                   dv_valid,
    input  logic [DATA_W-1:0]      dv_data,
    output logic                   match_o,
    output logic                   pending_o
);

    acc_class_e cls;
    dmode_e     dmode;
    acc_flags_t flags;
    logic       addr_ok, ctx_ok, secure_ok, kind_ok;
    logic       base_ok, now_pass, late_pass;

    assign cls   = acc_class_e'(acc_class);
    assign dmode = dmode_e'(cfg_dmode);
    assign flags = '{cancel: acc_cancel, miss: acc_miss, abort: acc_abort};

    qac_addr_ctx #(
        .ADDR_W(ADDR_W), .CTX_W(CTX_W), .N_CTX(N_CTX), .SEL_W(SEL_W)
    ) u_addr_ctx (
        .cfg_addr      (cfg_addr),
        .cfg_size      (size_e'(cfg_size)),
        .cfg_ctx_sel   (cfg_ctx_sel),
        .cfg_ctx_vals  (cfg_ctx_vals),
        .cfg_ctx_mask  (cfg_ctx_mask),
        .cfg_sec       (sec_e'(cfg_sec)),
        .acc_addr      (acc_addr),
        .acc_size      (size_e'(acc_size)),
        .acc_ctx       (acc_ctx),
        .acc_nonsecure (acc_nonsecure),
        .addr_ok       (addr_ok),
        .ctx_ok        (ctx_ok),
        .secure_ok     (secure_ok)
    );

    assign kind_ok = type_ok(acc_type_e'(cfg_type), cls, acc_cond_pass);
    assign base_ok = addr_ok && ctx_ok && secure_ok && kind_ok
                     && (dmode != DM_RSVD);

    // Data check on hit data now, and on late data for a waiting access.
    qac_data_cmp #(.DATA_W(DATA_W)) u_dcmp_now (
        .mode     (dmode),
        .cfg_val  (cfg_dval),
        .cfg_mask (cfg_dmask),
        .data     (acc_data),
        .pass     (now_pass)
    );

    qac_data_cmp #(.DATA_W(DATA_W)) u_dcmp_late (
        .mode     (dmode),
        .cfg_val  (cfg_dval),
        .cfg_mask (cfg_dmask),
        .data     (dv_data),
        .pass     (late_pass)
    );

    qac_resolve u_resolve (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .base_ok   (base_ok),
        .data_acc  (is_data(cls)),
        .flags     (flags),
        .exact     (cfg_exact),
        .dmode     (dmode),
        .now_pass  (now_pass),
        .dv_valid  (dv_valid),
        .late_pass (late_pass),
        .match_q   (match_o),
        .pending_q (pending_o)
    );

    // R2: reserved access type never yields an immediate match
    a_r2_rsvd_type: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (cfg_type == 3'b111) && !dv_valid) |=> !match_o);

    // R6: reserved security mode never yields an immediate match
    a_r6_rsvd_sec: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (cfg_sec == 2'b11) && !dv_valid) |=> !match_o);

    // R1: reserved size never yields an immediate match
    a_r1_rsvd_size: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (cfg_size == 2'b10) && !dv_valid) |=> !match_o);

endmodule

// File: tb/qual_addr_cmp_bench.sv
module qual_addr_cmp_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_addr, cfg_dval, cfg_dmask, cfg_ctx_mask;
    logic [1:0]  cfg_size, cfg_dmode, cfg_ctx_sel, cfg_sec;
    logic [2:0]  cfg_type;
    logic [95:0] cfg_ctx_vals;
    logic        cfg_exact;
    logic        acc_valid, acc_cond_pass, acc_cancel, acc_miss, acc_abort;
    logic [1:0]  acc_class, acc_size;
    logic [31:0] acc_addr, acc_data, acc_ctx;
    logic        acc_nonsecure;
    logic        dv_valid;
    logic [31:0] dv_data;
    logic        match_o, pending_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    qual_addr_cmp u_qual_addr_cmp (.*);

    typedef struct packed {
        logic [2:0]  ty;
        logic [1:0]  sz;
        logic [1:0]  cls;
        logic        pass;
        logic [1:0]  asz;
        logic [31:0] addr;
        logic        exp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{3'b000, 2'b11, 2'b00, 1'b0, 2'b11, 32'h1234, 1'b1},
        '{3'b000, 2'b11, 2'b01, 1'b1, 2'b11, 32'h1234, 1'b0},
        '{3'b001, 2'b11, 2'b01, 1'b0, 2'b11, 32'h1234, 1'b1},
        '{3'b010, 2'b11, 2'b01, 1'b1, 2'b11, 32'h1234, 1'b1},
        '{3'b010, 2'b11, 2'b01, 1'b0, 2'b11, 32'h1234, 1'b0},
        '{3'b011, 2'b11, 2'b01, 1'b0, 2'b11, 32'h1234, 1'b1},
        '{3'b100, 2'b11, 2'b10, 1'b0, 2'b11, 32'h1234, 1'b1},
        '{3'b100, 2'b11, 2'b11, 1'b0, 2'b11, 32'h1234, 1'b1},
        '{3'b101, 2'b11, 2'b11, 1'b0, 2'b11, 32'h1234, 1'b0},
        '{3'b110, 2'b11, 2'b11, 1'b0, 2'b11, 32'h1234, 1'b1},
        '{3'b111, 2'b11, 2'b10, 1'b0, 2'b11, 32'h1234, 1'b0},
        '{3'b000, 2'b11, 2'b00, 1'b0, 2'b11, 32'h1237, 1'b1},
        '{3'b000, 2'b11, 2'b00, 1'b0, 2'b11, 32'h1238, 1'b0},
        '{3'b000, 2'b01, 2'b00, 1'b0, 2'b01, 32'h1235, 1'b1},
        '{3'b000, 2'b01, 2'b00, 1'b0, 2'b01, 32'h1236, 1'b0},
        '{3'b000, 2'b00, 2'b00, 1'b0, 2'b00, 32'h1235, 1'b0},
        '{3'b000, 2'b00, 2'b00, 1'b0, 2'b00, 32'h1234, 1'b1},
        '{3'b000, 2'b11, 2'b00, 1'b0, 2'b01, 32'h1234, 1'b0},
        '{3'b000, 2'b10, 2'b00, 1'b0, 2'b10, 32'h1234, 1'b0}
    };

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic defaults();
        cfg_addr = 32'h1234; cfg_size = 2'b11; cfg_type = 3'b000;
        cfg_dmode = 2'b00; cfg_dval = 32'hCAFE_0000; cfg_dmask = 32'h0;
        cfg_ctx_sel = 2'b00; cfg_ctx_mask = 32'h0;
        cfg_ctx_vals = {32'h0000_0303, 32'h0000_0202, 32'h0000_0101};
        cfg_sec = 2'b00; cfg_exact = 1'b0;
        acc_valid = 0; acc_class = 2'b00; acc_cond_pass = 0; acc_cancel = 0;
        acc_miss = 0; acc_abort = 0; acc_addr = 32'h1234; acc_size = 2'b11;
        acc_data = 32'h0; acc_ctx = 32'h0; acc_nonsecure = 0;
        dv_valid = 0; dv_data = 32'h0;
    endtask

    // One-cycle access; result sampled at the next falling edge.
    task automatic access(input logic exp, input string what);
        @(negedge clk);
        acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        check(match_o, exp, what);
    endtask

    task automatic strobe(input logic [31:0] d);
        @(negedge clk);
        dv_valid = 1'b1; dv_data = d;
        @(negedge clk);
        dv_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        // R11: reset state
        check(match_o, 1'b0, "R11 reset match");
        check(pending_o, 1'b0, "R11 reset pending");
        rst = 1'b0;

        // R1 R2: table of type, class and alignment
        for (int i = 0; i < NV; i++) begin
            defaults();
            cfg_type = VEC[i].ty; cfg_size = VEC[i].sz;
            acc_class = VEC[i].cls; acc_cond_pass = VEC[i].pass;
            acc_size = VEC[i].asz; acc_addr = VEC[i].addr;
            access(VEC[i].exp, $sformatf("R1 R2 vector %0d", i));
        end

        // R10: pulse lasts one cycle
        defaults();
        access(1'b1, "R10 pulse");
        @(negedge clk);
        check(match_o, 1'b0, "R10 pulse ends");

        // R3: data modes on a hit load
        defaults(); cfg_type = 3'b101; acc_class = 2'b10;
        cfg_dmode = 2'b01; acc_data = 32'hCAFE_0000;
        access(1'b1, "R3 equal mode, equal data");
        acc_data = 32'hCAFE_0001;
        access(1'b0, "R3 equal mode, other data");
        cfg_dmode = 2'b11;
        access(1'b1, "R3 differ mode, other data");
        acc_data = 32'hCAFE_0000;
        access(1'b0, "R3 differ mode, equal data");
        cfg_dmode = 2'b10;
        access(1'b0, "R3 reserved mode load");
        acc_class = 2'b00; cfg_type = 3'b000;
        access(1'b0, "R3 reserved mode fetch");

        // R4: masked bits are ignored
        defaults(); cfg_type = 3'b101; acc_class = 2'b10; cfg_dmode = 2'b01;
        cfg_dmask = 32'h0000_00FF; acc_data = 32'hCAFE_00A5;
        access(1'b1, "R4 masked bits differ");
        acc_data = 32'hCAFE_01A5;
        access(1'b0, "R4 unmasked bit differs");

        // R5: context select and mask
        defaults(); acc_ctx = 32'h0000_0101;
        access(1'b1, "R5 select 0 ignores context");
        cfg_ctx_sel = 2'b10;
        access(1'b0, "R5 select 2 with value 1");
        acc_ctx = 32'h0000_0202;
        access(1'b1, "R5 select 2 with value 2");
        cfg_ctx_sel = 2'b11; acc_ctx = 32'h0000_0313;
        access(1'b0, "R5 select 3 unmasked diff");
        cfg_ctx_mask = 32'h0000_0010;
        access(1'b1, "R5 select 3 masked diff");

        // R6: security modes
        defaults(); cfg_sec = 2'b01; acc_nonsecure = 1'b1;
        access(1'b1, "R6 nonsecure mode, nonsecure");
        acc_nonsecure = 1'b0;
        access(1'b0, "R6 nonsecure mode, secure");
        cfg_sec = 2'b10;
        access(1'b1, "R6 secure mode, secure");
        cfg_sec = 2'b11;
        access(1'b0, "R6 reserved mode");

        // R7: cancelled instruction
        defaults(); acc_cancel = 1'b1; cfg_exact = 1'b1;
        access(1'b0, "R7 cancel exact");
        cfg_exact = 1'b0;
        access(1'b1, "R7 cancel not exact");

        // R8: abort and miss without exact
        defaults(); cfg_type = 3'b110; acc_class = 2'b11; cfg_dmode = 2'b01;
        acc_data = 32'h1; acc_abort = 1'b1; cfg_exact = 1'b1;
        access(1'b0, "R8 abort exact");
        cfg_exact = 1'b0;
        access(1'b1, "R8 abort not exact");
        acc_abort = 1'b0; acc_miss = 1'b1;
        access(1'b1, "R8 miss not exact");
        check(pending_o, 1'b0, "R8 miss not exact no pending");

        // R9: waiting data access
        defaults(); cfg_type = 3'b101; acc_class = 2'b10; cfg_dmode = 2'b01;
        cfg_exact = 1'b1; acc_miss = 1'b1;
        access(1'b0, "R9 miss exact no match");
        check(pending_o, 1'b1, "R9 pending raised");
        @(negedge clk);
        check(pending_o, 1'b1, "R9 pending held");
        strobe(32'hCAFE_0000);
        check(match_o, 1'b1, "R9 late data equal");
        check(pending_o, 1'b0, "R9 pending cleared");
        access(1'b0, "R9 second miss");
        strobe(32'hBEEF_0000);
        check(match_o, 1'b0, "R9 late data other");
        check(pending_o, 1'b0, "R9 pending cleared again");

        // R12: strobe with nothing pending
        strobe(32'hCAFE_0000);
        check(match_o, 1'b0, "R12 stray strobe match");
        check(pending_o, 1'b0, "R12 stray strobe pending");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule